// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker is called on a translation cache miss. It reads the leaf entry for a 32-bit virtual address from a two-level page table in memory, with 4 KB pages. A start pulse captures the virtual page number and the root page number of the current address space. The walker then issues one word read per level over a request/response memory port. The memory may answer after any number of cycles.

A walk ends in one of two ways. It may find a valid leaf, and then it returns the physical page number and the permission bits so the translation cache can be filled. Otherwise it raises a page fault. A leaf found at the first level is a 4 MB superpage. For a superpage the walker returns the 4 KB page number inside it, built from the upper part of the entry and the low virtual page index, and it flags the result as a superpage. Updates to the accessed and dirty bits are left to other logic.

Top module: `sv32_walker`

## Requirements
- R1: After reset, busy, mem_req, done_valid and fault are all low.
- R2: A start pulse seen while idle issues exactly one read at address root_ppn*4096 + VPN1*4. VPN1 is vaddr[31:22]. Every request address is word aligned.
- R3: A first-level entry that is valid, well formed and not a leaf leads to one second-level read at PPN*4096 + VPN0*4. PPN is pte[31:10] and VPN0 is vaddr[21:12].
- R4: A valid second-level leaf ends the walk. done_ppn is pte[31:10], done_perm is pte[7:1] (R, W, X, U, G, A, D from bit 0 up) and done_super is 0.
- R5: A first-level leaf whose pte[19:10] is zero ends the walk after a single read. done_super is 1 and done_ppn is {pte[31:20], VPN0}.
- R6: A first-level leaf with a nonzero pte[19:10] ends the walk with fault.
- R7: At either level, an entry with V (bit 0) clear, or with W (bit 2) set and R (bit 1) clear, ends the walk with fault. A leaf is an entry with R or X (bit 3) set.
- R8: A non-leaf entry read at the second level ends the walk with fault.
- R9: done_valid and fault are one-cycle pulses that never occur together. The cycle after either pulse, the walker is idle.
- R10: A start pulse while a walk is in progress has no effect. The result belongs to the address and root captured at the start of the walk.
- R11: A memory response that arrives while the walker is not waiting for one is ignored. The walker stays idle and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Start a walk (taken only while idle) |
| miss_vaddr | input | 32 | Virtual address to translate |
| root_ppn | input | 22 | Page number of the root table |
| busy | output | 1 | Walk in progress or result being reported |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 34 | Physical address of the entry to read |
| rsp_valid | input | 1 | Read data valid |
| rsp_pte | input | 32 | Page table entry read from memory |
| done_valid | output | 1 | Successful walk, result valid |
| done_ppn | output | 22 | Physical page number of the 4 KB page |
| done_perm | output | 7 | Permission and status bits of the leaf |
| done_super | output | 1 | Leaf was found at the first level |
| fault | output | 1 | Walk ended with a page fault |

## Verification
The bench builds the walker with its default widths: a 10-bit index per level and a 22-bit physical page number. This gives a 34-bit physical address space and a 12-bit superpage number. These widths let the bench place page tables and leaves above the 4 GB line, and they let a superpage leaf carry nonzero low page bits so that the alignment fault can be reached. A sparse memory model answers each read with a chosen latency. This covers the immediate answer and the delayed answer, and it allows a stray answer to arrive while the walker is idle.

// File: rtl/sv32_walker.sv
module sv32_walker #(
  parameter int VPN_W = 10,
  parameter int PPN_W = 22,
  localparam int OFF_W = VPN_W + 2,
  localparam int VA_W  = 2 * VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int PTE_W = PPN_W + 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             busy,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             rsp_valid,
  input  logic [PTE_W-1:0] rsp_pte,
  output logic             done_valid,
  output logic [PPN_W-1:0] done_ppn,
  output logic [6:0]       done_perm,
  output logic             done_super,
  output logic             fault
);
  typedef enum logic [2:0] {S_IDLE, S_REQ1, S_WAIT1, S_REQ0, S_WAIT0, S_DONE, S_FAULT} st_t;

  st_t st, st_n;
  logic [2*VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0]   base_q;
  logic [PTE_W-1:0]   pte_q;
  logic               super_q;

  wire [VPN_W-1:0] vpn1 = vpn_q[VPN_W +: VPN_W];
  wire [VPN_W-1:0] vpn0 = vpn_q[0 +: VPN_W];

  wire pte_bad   = !rsp_pte[0] || (rsp_pte[2] && !rsp_pte[1]);
  wire pte_leaf  = rsp_pte[1] || rsp_pte[3];
  wire pte_misal = |rsp_pte[10 +: VPN_W];

  assign busy       = st != S_IDLE;
  assign mem_req    = st == S_REQ1 || st == S_REQ0;
  assign mem_addr   = {base_q, (st == S_REQ1) ? vpn1 : vpn0, 2'b00};
  assign done_valid = st == S_DONE;
  assign fault      = st == S_FAULT;
  assign done_super = super_q;
  assign done_perm  = pte_q[7:1];
  assign done_ppn   = super_q ? {pte_q[PTE_W-1:10+VPN_W], vpn0} : pte_q[PTE_W-1:10];

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (miss_valid) st_n = S_REQ1;
      S_REQ1:  st_n = S_WAIT1;
      S_WAIT1: if (rsp_valid) begin
        if (pte_bad)        st_n = S_FAULT;
        else if (!pte_leaf) st_n = S_REQ0;
        else if (pte_misal) st_n = S_FAULT;
        else                st_n = S_DONE;
      end
      S_REQ0:  st_n = S_WAIT0;
      S_WAIT0: if (rsp_valid) st_n = (pte_bad || !pte_leaf) ? S_FAULT : S_DONE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      super_q <= 1'b0;
    end else begin
      st <= st_n;
      if (st == S_IDLE && miss_valid) begin
        vpn_q   <= miss_vaddr[VA_W-1:OFF_W];
        base_q  <= root_ppn;
        super_q <= 1'b0;
      end
      if ((st == S_WAIT1 || st == S_WAIT0) && rsp_valid) begin
        pte_q <= rsp_pte;
        if (st == S_WAIT1 && !pte_bad && !pte_leaf) base_q <= rsp_pte[PTE_W-1:10];
        if (st == S_WAIT1 && pte_leaf) super_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/walker_props.sv
module walker_props #(
  parameter int VPN_W = 10,
  parameter int PPN_W = 22,
  localparam int OFF_W = VPN_W + 2,
  localparam int VA_W  = 2 * VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int PTE_W = PPN_W + 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic [VA_W-1:0]  miss_vaddr,
  input logic [PPN_W-1:0] root_ppn,
  input logic             busy,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             rsp_valid,
  input logic [PTE_W-1:0] rsp_pte,
  input logic             done_valid,
  input logic [PPN_W-1:0] done_ppn,
  input logic [6:0]       done_perm,
  input logic             done_super,
  input logic             fault
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done_valid && !fault));
  p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && fault));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && !busy));
  p_fault_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!fault && !busy));
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_valid && !fault) |=> busy);
  p_idle_stray_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !miss_valid) |=> !busy);
endmodule

bind sv32_walker walker_props #(.VPN_W(VPN_W), .PPN_W(PPN_W)) i_props (.*);

// File: tb/test_sv32_walker.sv
`timescale 1ns/1ps
module test_sv32_walker;
  logic        clk = 0, rst_n = 0;
  logic        miss_valid = 0;
  logic [31:0] miss_vaddr = '0;
  logic [21:0] root_ppn = '0;
  logic        busy, mem_req, done_valid, done_super, fault;
  logic [33:0] mem_addr;
  logic        rsp_valid = 0;
  logic [31:0] rsp_pte = '0;
  logic [21:0] done_ppn;
  logic [6:0]  done_perm;

  sv32_walker i_sv32_walker (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] pt [logic [33:0]];
  logic [33:0] alog [4];
  int nreq = 0, delay = 0, stray = 0;

  logic g_done, g_fault, g_super;
  logic [21:0] g_ppn;
  logic [6:0]  g_perm;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers each read after 'delay' idle cycles
  initial begin
    logic pend = 0;
    logic [33:0] pa = '0;
    int wait_n = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (stray != 0) begin
        rsp_valid = 1; rsp_pte = (32'h00055 << 10) | 32'h0F; stray = 0;
      end else if (mem_req) begin
        if (nreq < 4) alog[nreq] = mem_addr;
        nreq++; pend = 1; pa = mem_addr; wait_n = delay;
      end else if (pend) begin
        if (wait_n > 0) wait_n--;
        else begin
          rsp_valid = 1;
          rsp_pte = pt.exists(pa) ? pt[pa] : 32'h0;
          pend = 0;
        end
      end
    end
  end

  function automatic logic [33:0] l1a(logic [21:0] root, logic [31:0] va);
    return {12'h0, root} * 34'd4096 + {24'h0, va[31:22]} * 34'd4;
  endfunction
  function automatic logic [33:0] l0a(logic [21:0] ppn, logic [31:0] va);
    return {12'h0, ppn} * 34'd4096 + {24'h0, va[21:12]} * 34'd4;
  endfunction
  function automatic logic [31:0] mk(logic [21:0] ppn, logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  task automatic run(logic [31:0] va, logic [21:0] root, bit poke);
    nreq = 0;
    g_done = 0; g_fault = 0;
    @(negedge clk);
    miss_valid = 1; miss_vaddr = va; root_ppn = root;
    @(negedge clk);
    miss_valid = 0;
    for (int c = 0; c < 40; c++) begin
      if (poke && c == 1) begin miss_valid = 1; miss_vaddr = ~va; root_ppn = ~root; end
      if (poke && c == 2) miss_valid = 0;
      if (done_valid || fault) begin
        g_done = done_valid; g_fault = fault;
        g_ppn = done_ppn; g_perm = done_perm; g_super = done_super;
        break;
      end
      @(negedge clk);
    end
    miss_valid = 0;
    @(negedge clk);
    chk("R9 pulse ends, idle", {done_valid, fault, busy}, 3'b000);
    chk("R9 walk terminated", g_done | g_fault, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 done/fault", {done_valid, fault}, 2'b00);
  endtask

  task automatic t_4k(logic [31:0] va, logic [21:0] root, logic [21:0] mid, logic [21:0] leaf, int dly);
    pt.delete(); delay = dly;
    pt[l1a(root, va)] = mk(mid, 8'h01);
    pt[l0a(mid, va)] = mk(leaf, 8'hD7);
    run(va, root, 0);
    chk("R4 done", {g_done, g_fault}, 2'b10);
    chk("R2 read count", nreq, 2);
    chk("R2 level-1 address", alog[0], l1a(root, va));
    chk("R3 level-0 address", alog[1], l0a(mid, va));
    chk("R4 ppn", g_ppn, leaf);
    chk("R4 perm", g_perm, 7'h6B);
    chk("R4 super", g_super, 0);
    delay = 0;
  endtask

  task automatic t_mega();
    logic [31:0] va = 32'hC0ABC123;
    pt.delete();
    pt[l1a(22'h00100, va)] = mk({12'hA5C, 10'h0}, 8'h4B);
    run(va, 22'h00100, 0);
    chk("R5 done", {g_done, g_fault}, 2'b10);
    chk("R5 single read", nreq, 1);
    chk("R5 super", g_super, 1);
    chk("R5 ppn", g_ppn, {12'hA5C, va[21:12]});
    chk("R5 perm", g_perm, 7'h25);
  endtask

  task automatic t_misaligned();
    logic [31:0] va = 32'h00400000;
    pt.delete();
    pt[l1a(22'h00200, va)] = mk({12'h001, 10'h004}, 8'h03);
    run(va, 22'h00200, 0);
    chk("R6 misaligned superpage fault", {g_done, g_fault}, 2'b01);
  endtask

  task automatic t_invalid();
    logic [31:0] va = 32'h12345000;
    pt.delete();
    pt[l1a(22'h00300, va)] = mk(22'h00400, 8'h0E);
    run(va, 22'h00300, 0);
    chk("R7 V clear at level 1", {g_done, g_fault}, 2'b01);
    chk("R7 no second read", nreq, 1);
    pt.delete();
    pt[l1a(22'h00300, va)] = mk(22'h00400, 8'h01);
    pt[l0a(22'h00400, va)] = mk(22'h00777, 8'h05);
    run(va, 22'h00300, 0);
    chk("R7 W without R at level 0", {g_done, g_fault}, 2'b01);
  endtask

  task automatic t_nonleaf_l0();
    logic [31:0] va = 32'h7FFFF000;
    pt.delete();
    pt[l1a(22'h00500, va)] = mk(22'h00600, 8'h01);
    pt[l0a(22'h00600, va)] = mk(22'h00700, 8'h01);
    run(va, 22'h00500, 0);
    chk("R8 non-leaf at level 0 fault", {g_done, g_fault}, 2'b01);
    chk("R8 read count", nreq, 2);
  endtask

  task automatic t_busy_start();
    logic [31:0] va = 32'h2468A000;
    pt.delete();
    pt[l1a(22'h00800, va)] = mk(22'h00900, 8'h01);
    pt[l0a(22'h00900, va)] = mk(22'h0BEEF, 8'h03);
    run(va, 22'h00800, 1);
    chk("R10 original walk completes", {g_done, g_fault}, 2'b10);
    chk("R10 ppn unaffected", g_ppn, 22'h0BEEF);
    chk("R10 no extra reads", nreq, 2);
  endtask

  task automatic t_stray();
    @(negedge clk);
    stray = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 stray response ignored", {busy, mem_req, done_valid, fault}, 4'b0000);
    t_4k(32'h00001000, 22'h00010, 22'h00011, 22'h00123, 0);
  endtask

  initial begin
    #500us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_4k(32'h0148D000, 22'h00010, 22'h00020, 22'h3ABCD, 0);
    t_4k(32'hFFC01ABC, 22'h3FFFF, 22'h20001, 22'h12345, 3);
    t_mega();
    t_misaligned();
    t_invalid();
    t_nonleaf_l0();
    t_busy_start();
    t_stray();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule